// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port

This block is one general-purpose I/O port of a small microcontroller. Software reaches it through a narrow synchronous register interface with a 2-bit select, a write strobe and a data byte. It keeps a per-pin direction register and a per-pin level register. The level register sets the driven value when a pin is an output and requests the weak pull-up when the pin is an input. From these registers, and from a chip-wide pull-up disable input, it decodes three controls per pin for the pad: output enable, output level and pull-up enable.

The external pin levels enter through a two-stage synchronizer. The first stage is transparent while the clock is high and closes on the falling edge. The second stage is a flop loaded on the rising edge. Reading the pin select returns the synchronized levels. Writing the pin select does not store anything. Each 1 bit in the written byte flips the matching bit of the level register, so a single bit can be toggled without a read-modify-write sequence.

The block has no state machine. Its only sequential elements are the two configuration registers and the two synchronizer stages. Select code 3 is unused.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and level registers hold zero, and every pin is a high-impedance input: output enable 0, output level 0, pull-up 0.
- R2: A write with select 0 loads the direction register, and a write with select 1 loads the level register. Reads with select 0 and 1 return those stored values whatever the pin levels are.
- R3: A write with select 2 inverts every level-register bit whose written bit is 1 and keeps every bit whose written bit is 0, whatever the direction bits are. The direction register is left unchanged.
- R4: A pin with direction 0 and level 0 has output enable 0 and pull-up 0.
- R5: A pin with direction 0 and level 1 has its pull-up enabled while the pull-up disable input is 0, and its output enable stays 0.
- R6: While the pull-up disable input is 1, every pull-up enable is 0.
- R7: A pin with direction 1 has output enable 1, pull-up 0 and output level equal to its level bit. A pin with direction 0 has output level 0.
- R8: A read with select 2 returns the synchronized pin levels for any direction setting, including pins that are driven.
- R9: The level a pin has at a falling clock edge appears at select 2 from the next rising edge on. A change made after a falling edge is not visible before the first rising edge that follows the next falling edge.
- R10: Select 3 reads as zero. A write with select 3 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Register select: 0 direction, 1 level, 2 pin/toggle, 3 unused |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data of the selected register |
| pull_dis | input | 1 | Chip-wide pull-up disable |
| pad_in | input | 8 | External pin levels, asynchronous to clk |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven level |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The pin decode is exercised with random sequences of direction, level, toggle and unused-select writes, with the pull-up disable input flipped at random. This covers all four direction/level combinations on every pin, both with and without the pull-up disable, and separates a wrong pull-up gate from a wrong drive gate. Toggle writes are applied with all-ones and alternating patterns over both input and output pins, which shows whether zero bits are kept and whether the toggle depends on direction. Pin changes are placed once in the high clock phase and once in the low phase. The input register is sampled just before and just after the expected rising edge, which exposes a synchronizer that is one stage too short or one stage too long.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_LVL  = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] lvl_q
);
    port_sel_e   sel_e;
    logic [WIDTH-1:0] dir_d, lvl_d;

    assign sel_e = port_sel_e'(sel);

    always_comb begin
        dir_d = dir_q;
        lvl_d = lvl_q;
        if (wr_en) begin
            unique case (sel_e)
                SEL_DIR:  dir_d = wdata;
                SEL_LVL:  lvl_d = wdata;
                SEL_PIN:  lvl_d = lvl_q ^ wdata;
                SEL_NONE: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            lvl_q <= '0;
        end else begin
            dir_q <= dir_d;
            lvl_q <= lvl_d;
        end
    end

    // R3: a toggle write flips exactly the written ones
    p_toggle_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'd2) |=> (lvl_q == ($past(lvl_q) ^ $past(wdata))) && $stable(dir_q));

    // R10: the unused select touches no register
    p_unused_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'd3) |=> $stable(lvl_q) && $stable(dir_q));

    // R2: without a write the registers hold their values
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(lvl_q) && $stable(dir_q));
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] lvl,
    input  logic             pull_dis,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] drv,
    output logic [WIDTH-1:0] pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        always_comb begin
            oe[i]  = dir[i];
            drv[i] = dir[i] & lvl[i];
            pu[i]  = ~dir[i] & lvl[i] & ~pull_dis;
        end
    end

    // R6: the chip-wide disable silences every pull-up
    p_pull_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pull_dis |-> (pu == '0));

    // R7: a driven pin never also pulls up
    p_drive_no_pull_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((oe & pu) == '0));

    // R7: an undriven pin presents a low output level
    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv & ~oe) == '0));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pin_q
);
    logic [WIDTH-1:0] hold_q;

    // First stage: follows the pin while clk is high, frozen at the falling edge.
    // Only its frozen value is ever consumed, so it is captured on that edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= pad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= hold_q;
    end

    // R9: the register stage loads the first stage's held value
    p_stage_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pin_q == $past(hold_q));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  logic             pull_dis,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);
    logic [WIDTH-1:0] dir_q, lvl_q, pin_q;

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
        .wdata(wdata), .dir_q(dir_q), .lvl_q(lvl_q)
    );

    gpio_pin_cfg #(.WIDTH(WIDTH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .dir(dir_q), .lvl(lvl_q),
        .pull_dis(pull_dis), .oe(pad_oe), .drv(pad_out), .pu(pad_pu)
    );

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pin_q(pin_q)
    );

    always_comb begin
        unique case (port_sel_e'(sel))
            SEL_DIR:  rdata = dir_q;
            SEL_LVL:  rdata = lvl_q;
            SEL_PIN:  rdata = pin_q;
            SEL_NONE: rdata = '0;
        endcase
    end

    // R2: the direction read-back matches the enables sent to the pads
    p_dir_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd0) |-> (rdata == pad_oe));

    // R10: the unused select reads as zero
    p_unused_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd3) |-> (rdata == '0));
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   sel = 2'd0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         pull_dis = 1'b0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_oe, pad_out, pad_pu;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [W-1:0] m_dir = '0;
    logic [W-1:0] m_lvl = '0;

    gpio_port #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pull_dis(pull_dis), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] f_pu(logic [W-1:0] d, logic [W-1:0] l, logic pd);
        return ~d & l & {W{~pd}};
    endfunction

    function automatic logic [W-1:0] f_drv(logic [W-1:0] d, logic [W-1:0] l);
        return d & l;
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] s, logic [W-1:0] d);
        @(negedge clk);
        #1;
        sel = s; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        case (s)
            2'd0: m_dir = d;
            2'd1: m_lvl = d;
            2'd2: m_lvl = m_lvl ^ d;
            default: ;
        endcase
    endtask

    task automatic bus_read(logic [1:0] s, output logic [W-1:0] v);
        sel = s;
        #1;
        v = rdata;
    endtask

    task automatic check_pins(string tag);
        logic [W-1:0] v;
        bus_read(2'd0, v); chk({tag, " R2 dir read"}, v, m_dir);
        bus_read(2'd1, v); chk({tag, " R2 lvl read"}, v, m_lvl);
        chk({tag, " R7 oe"}, pad_oe, m_dir);
        chk({tag, " R7 drive"}, pad_out, f_drv(m_dir, m_lvl));
        chk({tag, " R5 pull"}, pad_pu, f_pu(m_dir, m_lvl, pull_dis));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1 oe", pad_oe, '0);
        chk("R1 drive", pad_out, '0);
        chk("R1 pull", pad_pu, '0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check_pins("R1 after release");

        // R4/R5/R7 directed: mixed pins
        bus_write(2'd0, 8'hF0);
        bus_write(2'd1, 8'hCC);
        check_pins("R4 mixed");
        pull_dis = 1'b1; #1;
        chk("R6 pull disabled", pad_pu, '0);
        pull_dis = 1'b0; #1;
        chk("R5 pull restored", pad_pu, 8'h0C);

        // R3: toggle over outputs and inputs, both ways
        bus_write(2'd2, 8'hFF);
        check_pins("R3 toggle all");
        bus_read(2'd1, v); chk("R3 lvl after all-ones", v, 8'h33);
        bus_write(2'd2, 8'h5A);
        bus_read(2'd1, v); chk("R3 lvl after 5A", v, 8'h69);
        bus_read(2'd0, v); chk("R3 dir untouched", v, 8'hF0);
        bus_write(2'd2, 8'h00);
        bus_read(2'd1, v); chk("R3 zero toggle", v, 8'h69);

        // R10: unused select
        bus_write(2'd3, 8'hA5);
        bus_read(2'd3, v); chk("R10 read zero", v, '0);
        check_pins("R10 write ignored");

        // R9: change in the high phase
        @(posedge clk); #2;
        pad_in = 8'hA5;
        sel = 2'd2;
        #5; chk("R9 high-phase early", rdata, 8'h00);
        @(posedge clk); #2;
        chk("R9 high-phase arrive", rdata, 8'hA5);
        // R9: change in the low phase
        @(negedge clk); #2;
        pad_in = 8'h3C;
        @(posedge clk); #2;
        chk("R9 low-phase early", rdata, 8'hA5);
        @(posedge clk); #2;
        chk("R9 low-phase arrive", rdata, 8'h3C);

        // R8: pin read while all pins drive
        bus_write(2'd0, 8'hFF);
        pad_in = 8'h96;
        repeat (2) @(posedge clk);
        #2;
        bus_read(2'd2, v); chk("R8 read while driving", v, 8'h96);

        // Random register traffic
        for (int i = 0; i < 400; i++) begin
            logic [1:0] s;
            s = 2'($urandom % 4);
            pull_dis = 1'($urandom % 2);
            bus_write(s, W'($urandom));
            check_pins("R3 random");
        end

        // Random asynchronous pin traffic
        for (int i = 0; i < 100; i++) begin
            logic [W-1:0] p;
            p = W'($urandom);
            @(posedge clk);
            #(1 + ($urandom % 4));
            pad_in = p;
            @(posedge clk); #2;
            @(posedge clk); #2;
            bus_read(2'd2, v); chk("R8 random pin", v, p);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule